// File: doc/BRIEF.md
# I2C Bus Bit Timing Generator

This block is the bit-level line sequencer inside an I2C master. From a single input clock it drives two active-high pull-low enables, one for SCL and one for SDA. It takes one command at a time over a valid/ready interface. The commands are START, repeated START, send bit, receive bit and STOP. Each command ends with a single-cycle `done` pulse. A receive also returns the sampled bit on `rd_bit`. Byte framing, acknowledge policy, addressing and arbitration are handled by the logic above this block.

The bus clock is built from two divider inputs. With l = `div_low`+1 and h = `div_high`+1, SCL is held low for 8·l cycles and released for 8·h cycles. Three small count fields set the remaining timing:
- `upd_cnt` places the SDA change inside the low phase.
- `sta_cnt` sets how long the START setup lasts.
- `sto_cnt` sets how long the STOP setup lasts.

A parameter selects the older timing variant. In that variant SDA moves at a fixed 7/8 point of the high phase and the count fields are ignored.

Back-pressure: `cmd_ready` is high only while the sequencer is idle. A command transfers on a clock edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` drops in the next cycle and stays low until the cycle after `done`. The upstream logic must hold `cmd_op` and `cmd_wbit` steady while `cmd_valid` is high and `cmd_ready` is low. Nothing presented during that time is consumed.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe` and `done` are 0 and `cmd_ready` is 1.
- R2: A command transfers on an edge with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is low from the next cycle through the `done` cycle and high in the cycle after `done`. `done` lasts one cycle. Commands offered while `cmd_ready` is low are ignored. Command codes are 0 START, 1 repeated START, 2 send, 3 receive and 4 STOP. Codes 5 to 7 raise `done` in the cycle after the transfer and leave both lines unchanged.
- R3: Repeated START, send, receive and STOP pull SCL low in the cycle after the transfer and release it 8·l cycles later. A divider of 0 gives 8 cycles.
- R4: For send and receive, `done` rises 8·h cycles after SCL is released. SCL then stays released until the next command.
- R5: With s = `upd_cnt`+1 (values 1 to 4), SDA takes its new value l·s+1 cycles after SCL is pulled low. For a send, `sda_oe` becomes the inverse of `cmd_wbit`. Receive and repeated START release SDA, and STOP pulls it low.
- R6: A receive latches `sda_in` at the clock edge 4·h cycles after SCL is released. `rd_bit` holds that value through `done` and changes for no other command.
- R7: With u = `sta_cnt`+1, START releases SDA in the cycle after the transfer. It pulls SDA low 8·h·u+1 cycles after the transfer and raises `done` 8·h·(2u+1) cycles after the transfer. SCL stays released throughout.
- R8: Repeated START follows the R7 timing, measured from the SCL release that ends its low phase.
- R9: With p = `sto_cnt`+1, STOP releases SDA 8·h·p+1 cycles after SCL is released and raises `done` in that same cycle. Both lines are then released.
- R10: Dividers and count fields are captured when a command transfers. Changes made while a command runs take effect from the next command.
- R11: `version` equals the VERSION parameter. With VERSION 0 the count fields are ignored and the SDA change point is fixed at 4·l+1. START pulls SDA low 7·h cycles after the transfer and completes at 8·h. Repeated START does the same from the SCL release. STOP releases SDA and completes 7·h cycles after the SCL release.
- R12: SCL is never pulled low while `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can transfer |
| cmd_op | input | 3 | Command code |
| cmd_wbit | input | 1 | Bit to send |
| div_low | input | DIV_W | Low-phase divider, implicit +1 |
| div_high | input | DIV_W | High-phase divider, implicit +1 |
| upd_cnt | input | 2 | SDA change point in the low phase, implicit +1 |
| sta_cnt | input | 2 | START setup count, implicit +1 |
| sto_cnt | input | 2 | STOP setup count, implicit +1 |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| done | output | 1 | Command completed, one-cycle pulse |
| rd_bit | output | 1 | Received bit, valid with `done` |
| version | output | 16 | Timing variant identifier |

## Verification
The bench compares both lines against a cycle-by-cycle model for every divider pair in 0..2 and every count value. This includes zero dividers, where a design that skips the implicit +1 would stall SCL or shorten a phase to nothing. During a receive, `sda_in` carries the wanted value for exactly one cycle, so a sample point off by even one edge returns the wrong bit. A command is poked and the timing inputs are rewritten in the middle of a transfer; a design that failed to capture its fields, or that accepted a second command, would distort the running waveform. An undefined code and the 7/8 variant are also run. A design mishandling the undefined code would move a line or never answer, and a variant wired to the wrong count would shift the START and STOP edges.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_RESTART = 3'd1,
    OP_SEND    = 3'd2,
    OP_RECV    = 3'd3,
    OP_STOP    = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_DONE = 2'd3
  } st_e;

  localparam int unsigned FIELD_W = 2;

endpackage

// File: rtl/i2c_bt_tick.sv
module i2c_bt_tick #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt
);

  // Phase-relative cycle counter: reads k after the k-th edge of a phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else            cnt <= cnt + CNT_W'(1);
  end

endmodule

// File: rtl/i2c_bt_marks.sv
module i2c_bt_marks
  import i2c_bt_pkg::*;
#(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned CNT_W   = DIV_W + 8,
  parameter int unsigned VERSION = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [DIV_W-1:0]   div_low,
  input  logic [DIV_W-1:0]   div_high,
  input  logic [FIELD_W-1:0] upd_cnt,
  input  logic [FIELD_W-1:0] sta_cnt,
  input  logic [FIELD_W-1:0] sto_cnt,
  output logic [CNT_W-1:0]   data_pt,
  output logic [CNT_W-1:0]   low_end,
  output logic [CNT_W-1:0]   high_end,
  output logic [CNT_W-1:0]   sample_pt,
  output logic [CNT_W-1:0]   sta_fall,
  output logic [CNT_W-1:0]   sta_done,
  output logic [CNT_W-1:0]   sto_rise
);

  localparam int unsigned MUL_W = DIV_W + 1;
  localparam int unsigned CW_W  = FIELD_W + 1;

  logic [MUL_W-1:0] l_q, h_q;
  logic [CNT_W-1:0] lw, hw, h8;

  // Capture the phase multipliers with the implicit +1 so zero never stalls.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_q <= MUL_W'(1);
      h_q <= MUL_W'(1);
    end else if (load) begin
      l_q <= MUL_W'(div_low) + MUL_W'(1);
      h_q <= MUL_W'(div_high) + MUL_W'(1);
    end
  end

  assign lw        = CNT_W'(l_q);
  assign hw        = CNT_W'(h_q);
  assign h8        = hw << 3;
  assign low_end   = (lw << 3) - CNT_W'(1);
  assign high_end  = h8 - CNT_W'(1);
  assign sample_pt = (hw << 2) - CNT_W'(1);

  generate
    if (VERSION == 0) begin : g_fixed
      // Fixed variant: SDA moves at 7/8 of the high phase, data at mid-low.
      logic [CNT_W-1:0] h7;
      assign h7       = h8 - hw;
      assign data_pt  = lw << 2;
      assign sta_fall = h7 - CNT_W'(1);
      assign sta_done = high_end;
      assign sto_rise = h7 - CNT_W'(1);
    end else begin : g_prog
      logic [CW_W-1:0]  s_q, u_q, p_q;
      logic [CNT_W-1:0] sw, uw, pw;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s_q <= CW_W'(1);
          u_q <= CW_W'(1);
          p_q <= CW_W'(1);
        end else if (load) begin
          s_q <= CW_W'(upd_cnt) + CW_W'(1);
          u_q <= CW_W'(sta_cnt) + CW_W'(1);
          p_q <= CW_W'(sto_cnt) + CW_W'(1);
        end
      end

      assign sw       = CNT_W'(s_q);
      assign uw       = CNT_W'(u_q);
      assign pw       = CNT_W'(p_q);
      assign data_pt  = lw * sw;
      assign sta_fall = h8 * uw;
      assign sta_done = h8 * ((uw << 1) + CNT_W'(1)) - CNT_W'(1);
      assign sto_rise = h8 * pw;
    end
  endgenerate

endmodule

// File: rtl/i2c_bt_seq.sv
module i2c_bt_seq
  import i2c_bt_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic             cmd_wbit,
  input  logic             sda_in,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] data_pt,
  input  logic [CNT_W-1:0] low_end,
  input  logic [CNT_W-1:0] high_end,
  input  logic [CNT_W-1:0] sample_pt,
  input  logic [CNT_W-1:0] sta_fall,
  input  logic [CNT_W-1:0] sta_done,
  input  logic [CNT_W-1:0] sto_rise,
  output logic             cnt_clear,
  output logic             load,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             done,
  output logic             rd_bit
);

  st_e  state;
  op_e  op_q;
  logic wbit_q;
  logic sda_next;
  logic accept, low_last;

  assign cmd_ready = (state == ST_IDLE);
  assign accept    = cmd_ready && cmd_valid;
  assign low_last  = (state == ST_LOW) && (cnt == low_end);
  assign cnt_clear = accept || low_last;
  assign load      = accept;

  always_comb begin
    unique case (op_q)
      OP_SEND: sda_next = ~wbit_q;
      OP_STOP: sda_next = 1'b1;
      default: sda_next = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      op_q   <= OP_SEND;
      wbit_q <= 1'b0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      done   <= 1'b0;
      rd_bit <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_q   <= op_e'(cmd_op);
            wbit_q <= cmd_wbit;
            case (cmd_op)
              OP_START: begin
                state  <= ST_HIGH;
                scl_oe <= 1'b0;
                sda_oe <= 1'b0;
              end
              OP_RESTART, OP_SEND, OP_RECV, OP_STOP: begin
                state  <= ST_LOW;
                scl_oe <= 1'b1;
              end
              default: begin
                state <= ST_DONE;
                done  <= 1'b1;
              end
            endcase
          end
        end
        ST_LOW: begin
          if (cnt == data_pt) sda_oe <= sda_next;
          if (low_last) begin
            scl_oe <= 1'b0;
            state  <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          case (op_q)
            OP_START, OP_RESTART: begin
              if (cnt == sta_fall) sda_oe <= 1'b1;
              if (cnt == sta_done) begin
                done  <= 1'b1;
                state <= ST_DONE;
              end
            end
            OP_STOP: begin
              if (cnt == sto_rise) begin
                sda_oe <= 1'b0;
                done   <= 1'b1;
                state  <= ST_DONE;
              end
            end
            default: begin
              if (op_q == OP_RECV && cnt == sample_pt) rd_bit <= sda_in;
              if (cnt == high_end) begin
                done  <= 1'b1;
                state <= ST_DONE;
              end
            end
          endcase
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Handshake: a transfer always closes the window for the next cycle.
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // Completion is a single pulse and is followed by readiness.
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready));

  // The clock line is never held low between commands.
  assert_scl_free_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !scl_oe);

  // SDA moves while SCL is released only for START, repeated START and STOP.
  assert_sda_steady_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && (sda_oe != $past(sda_oe)))
      |-> (op_q inside {OP_START, OP_RESTART, OP_STOP}));

  // Only a receive may alter the returned bit.
  assert_rdbit_recv_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_bit) |-> (op_q == OP_RECV));

  // STOP completion leaves both lines released.
  assert_stop_frees_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_STOP) |-> (!scl_oe && !sda_oe));

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
  import i2c_bt_pkg::*;
#(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned VERSION = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [2:0]         cmd_op,
  input  logic               cmd_wbit,
  input  logic [DIV_W-1:0]   div_low,
  input  logic [DIV_W-1:0]   div_high,
  input  logic [FIELD_W-1:0] upd_cnt,
  input  logic [FIELD_W-1:0] sta_cnt,
  input  logic [FIELD_W-1:0] sto_cnt,
  input  logic               sda_in,
  output logic               scl_oe,
  output logic               sda_oe,
  output logic               done,
  output logic               rd_bit,
  output logic [15:0]        version
);

  localparam int unsigned CNT_W = DIV_W + 8;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] data_pt, low_end, high_end, sample_pt;
  logic [CNT_W-1:0] sta_fall, sta_done, sto_rise;
  logic             cnt_clear, load;

  assign version = 16'(VERSION);

  i2c_bt_tick #(.CNT_W(CNT_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (cnt_clear),
    .cnt   (cnt)
  );

  i2c_bt_marks #(.DIV_W(DIV_W), .CNT_W(CNT_W), .VERSION(VERSION)) u_marks (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .div_low   (div_low),
    .div_high  (div_high),
    .upd_cnt   (upd_cnt),
    .sta_cnt   (sta_cnt),
    .sto_cnt   (sto_cnt),
    .data_pt   (data_pt),
    .low_end   (low_end),
    .high_end  (high_end),
    .sample_pt (sample_pt),
    .sta_fall  (sta_fall),
    .sta_done  (sta_done),
    .sto_rise  (sto_rise)
  );

  i2c_bt_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_wbit  (cmd_wbit),
    .sda_in    (sda_in),
    .cnt       (cnt),
    .data_pt   (data_pt),
    .low_end   (low_end),
    .high_end  (high_end),
    .sample_pt (sample_pt),
    .sta_fall  (sta_fall),
    .sta_done  (sta_done),
    .sto_rise  (sto_rise),
    .cnt_clear (cnt_clear),
    .load      (load),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .done      (done),
    .rd_bit    (rd_bit)
  );

endmodule

// File: tb/i2c_bit_timer_bench.sv
module i2c_bit_timer_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  valid_i = 2'b00;
  logic [2:0]  op_i = 3'd0;
  logic        wbit_i = 1'b0;
  logic [15:0] dl_i = 16'd0;
  logic [15:0] dh_i = 16'd0;
  logic [1:0]  upd_i = 2'd0, sta_i = 2'd0, sto_i = 2'd0;
  logic        sda_in_i = 1'b1;

  logic        rdy0, rdy1, scl0, scl1, sda0, sda1, dn0, dn1, rd0, rd1;
  logic [15:0] ver0, ver1;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  bit sda_hist [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_bit_timer #(.DIV_W(16), .VERSION(1)) u_i2c_bit_timer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(valid_i[1]), .cmd_ready(rdy1),
    .cmd_op(op_i), .cmd_wbit(wbit_i), .div_low(dl_i), .div_high(dh_i),
    .upd_cnt(upd_i), .sta_cnt(sta_i), .sto_cnt(sto_i), .sda_in(sda_in_i),
    .scl_oe(scl1), .sda_oe(sda1), .done(dn1), .rd_bit(rd1), .version(ver1)
  );

  i2c_bit_timer #(.DIV_W(16), .VERSION(0)) u_i2c_bit_timer_v0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(valid_i[0]), .cmd_ready(rdy0),
    .cmd_op(op_i), .cmd_wbit(wbit_i), .div_low(dl_i), .div_high(dh_i),
    .upd_cnt(upd_i), .sta_cnt(sta_i), .sto_cnt(sto_i), .sda_in(sda_in_i),
    .scl_oe(scl0), .sda_oe(sda0), .done(dn0), .rd_bit(rd0), .version(ver0)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string line_tag(input int v, input int op, input bit poke, input string base);
    if (v == 0) return "R11";
    if (poke) return "R10";
    return base;
  endfunction

  // Runs one command and compares every cycle against the arithmetic model.
  task automatic run_cmd(input int v, input int op, input bit wb, input bit poke);
    int l, h, s, u, p, kd, fk, rk, dk;
    int bad_scl, bad_sda, bad_done, a_scl, a_sda, e_scl_f, e_sda_f;
    bit old_sda, e_scl, e_sda, o_scl, o_sda, o_dn, o_rdy, o_rd;
    string ts, td;
    l = int'(dl_i) + 1; h = int'(dh_i) + 1;
    s = v ? int'(upd_i) + 1 : 4;
    u = int'(sta_i) + 1; p = int'(sto_i) + 1;
    fk = v ? 8*h*u + 1 : 7*h;
    rk = v ? 8*l + 8*h*p + 1 : 8*l + 7*h;
    dk = l*s + 1;
    case (op)
      0: kd = v ? 8*h*(2*u+1) : 8*h;
      1: kd = 8*l + (v ? 8*h*(2*u+1) : 8*h);
      2, 3: kd = 8*l + 8*h;
      4: kd = rk;
      default: kd = 0;
    endcase
    old_sda = sda_hist[v];
    bad_scl = -1; bad_sda = -1; bad_done = -1;
    a_scl = 0; a_sda = 0; e_scl_f = 0; e_sda_f = 0;
    @(negedge clk);
    while (!(v ? rdy1 : rdy0)) @(negedge clk);
    op_i = 3'(op); wbit_i = wb; valid_i[v] = 1'b1;
    @(negedge clk);
    valid_i[v] = 1'b0;
    for (int k = 0; k <= kd + 1; k++) begin
      if (k > 0) @(negedge clk);
      sda_in_i = (op == 3) ? ((k == 8*l + 4*h - 1) ? wb : ~wb) : 1'b1;
      if (poke && k == 2) begin valid_i[v] = 1'b1; op_i = 3'd4; end
      if (poke && k == 3) begin
        valid_i[v] = 1'b0; op_i = 3'(op);
        dl_i = 16'd3; dh_i = 16'd2; upd_i = 2'd2; sta_i = 2'd3; sto_i = 2'd1;
      end
      o_scl = v ? scl1 : scl0; o_sda = v ? sda1 : sda0;
      o_dn = v ? dn1 : dn0; o_rdy = v ? rdy1 : rdy0;
      e_scl = (op >= 1 && op <= 4) && (k < 8*l);
      case (op)
        0: e_sda = (k >= fk);
        1: e_sda = (k >= 8*l + fk) ? 1'b1 : ((k >= dk) ? 1'b0 : old_sda);
        2: e_sda = (k >= dk) ? ~wb : old_sda;
        3: e_sda = (k >= dk) ? 1'b0 : old_sda;
        4: e_sda = (k < dk) ? old_sda : (k < rk);
        default: e_sda = old_sda;
      endcase
      if (o_scl != e_scl && bad_scl < 0) begin bad_scl = k; a_scl = o_scl; e_scl_f = e_scl; end
      if (o_sda != e_sda && bad_sda < 0) begin bad_sda = k; a_sda = o_sda; e_sda_f = e_sda; end
      if (o_dn != (k == kd) && bad_done < 0) bad_done = k;
      if (k == kd) begin
        o_rd = v ? rd1 : rd0;
        if (op == 3)
          check(o_rd == wb, line_tag(v, op, poke, "R6 rd_bit"), o_rd, wb);
        check(o_rdy == 1'b0, line_tag(v, op, poke, "R2 ready during done"), o_rdy, 0);
      end
      if (k == kd + 1) begin
        check(o_rdy == 1'b1, line_tag(v, op, poke, "R2 ready after done"), o_rdy, 1);
        sda_hist[v] = e_sda;
      end
    end
    ts = (op == 0) ? "R7 sda" : (op == 1) ? "R8 sda" : (op == 4) ? "R9 sda" : "R5 sda";
    td = (op == 0) ? "R7 done" : (op == 1) ? "R8 done" : (op == 4) ? "R9 done" :
         (op > 4) ? "R2 done" : "R4 done";
    check(bad_scl < 0, line_tag(v, op, poke, "R3 scl"), a_scl, e_scl_f);
    check(bad_sda < 0, line_tag(v, op, poke, ts), a_sda, e_sda_f);
    check(bad_done < 0, line_tag(v, op, poke, td), bad_done, kd);
    if (bad_scl >= 0 || bad_sda >= 0 || bad_done >= 0)
      $display("  detail v=%0d op=%0d l=%0d h=%0d s=%0d u=%0d p=%0d at k scl=%0d sda=%0d done=%0d",
               v, op, l, h, s, u, p, bad_scl, bad_sda, bad_done);
  endtask

  task automatic frame(input int v, input int c);
    run_cmd(v, 0, 1'b0, 1'b0);
    run_cmd(v, 2, c[0], 1'b0);
    run_cmd(v, 3, ~c[0], 1'b0);
    run_cmd(v, 2, ~c[0], 1'b0);
    run_cmd(v, 1, 1'b0, 1'b0);
    run_cmd(v, 3, c[1], 1'b0);
    run_cmd(v, 4, 1'b0, 1'b0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    checks++; fails++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    sda_hist[0] = 1'b0; sda_hist[1] = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state of both variants
    check(scl1 == 0 && sda1 == 0, "R1 lines", {scl1, sda1}, 0);
    check(dn1 == 0 && rdy1 == 1, "R1 done/ready", {dn1, rdy1}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(scl1 == 0 && sda1 == 0 && rdy1 == 1 && dn1 == 0, "R1 after release",
          {scl1, sda1, rdy1, dn1}, 2);
    check(ver1 == 16'd1, "R11 version v1", ver1, 1);
    check(ver0 == 16'd0, "R11 version v0", ver0, 0);

    // Sweep dividers and counts: R3 R4 R5 R6 R7 R8 R9
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 4; c++) begin
          dl_i = 16'(a); dh_i = 16'(b);
          upd_i = 2'(c); sta_i = 2'((c + 1) % 4); sto_i = 2'((c + 2) % 4);
          frame(1, c);
        end

    // Larger dividers
    dl_i = 16'd40; dh_i = 16'd25; upd_i = 2'd3; sta_i = 2'd3; sto_i = 2'd3;
    frame(1, 2);

    // R10: mid-command poke and field rewrite, then new values apply
    dl_i = 16'd1; dh_i = 16'd0; upd_i = 2'd0; sta_i = 2'd0; sto_i = 2'd0;
    run_cmd(1, 0, 1'b0, 1'b0);
    run_cmd(1, 2, 1'b0, 1'b1);
    run_cmd(1, 3, 1'b1, 1'b0);
    run_cmd(1, 4, 1'b0, 1'b0);

    // R2: undefined code completes at once with lines untouched
    run_cmd(1, 5, 1'b0, 1'b0);
    run_cmd(1, 7, 1'b1, 1'b0);
    @(negedge clk);
    check(scl1 == 0 && rdy1 == 1, "R12 idle after stop", {scl1, rdy1}, 1);

    // R11: fixed 7/8 variant
    for (int a = 0; a < 3; a++) begin
      dl_i = 16'(a); dh_i = 16'(2 - a); upd_i = 2'(a); sta_i = 2'd3; sto_i = 2'd2;
      frame(0, a);
    end

    summary();
  end

endmodule